// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is wanted. A look-up table in a small word-addressed RAM holds identifiers in four sections: single standard identifiers, standard identifier ranges, single extended identifiers and extended identifier ranges. Each entry is tagged with the source channel it applies to. Five boundary registers give byte addresses that place the sections one after another. Each section runs from its own start register up to the next register.

A lookup takes the identifier, frame format and source channel of a received frame. It scans only the two sections for that frame format, the single-identifier section first and then the range section. It reads one table word per evaluation step. It finishes with a one-cycle done pulse that carries the accept or reject verdict, the section that matched and the entry index within that section. The table write port and the boundary registers are frozen while a lookup is running.

Top module: `can_id_filter`

## Requirements
- R1: A single-standard word holds two 16-bit entries. The upper half-word is the lower-indexed entry. Entry bits are: channel 15:13, disable 12, reserved 11 (written zero, compared as identifier bit 11), identifier 10:0. A standard frame whose channel and identifier equal an enabled entry is accepted with match_sect 0 and match_idx = 2 × word offset + (0 for the upper half, 1 for the lower half).
- R2: An entry whose disable bit is set never produces a match, even when its channel and identifier agree.
- R3: A standard-range word holds the lower bound in its upper half and the upper bound in its lower half, both in the R1 layout. It matches when neither disable bit is set, the frame channel equals the lower bound's channel and lower ≤ identifier ≤ upper. Result: match_sect 1, match_idx = word offset.
- R4: A single-extended word holds the channel in bits 31:29 and a 29-bit identifier in bits 28:0. An equal channel and identifier give match_sect 2 and match_idx = word offset.
- R5: An extended range uses two consecutive words in the R4 layout: the lower bound, then the upper bound. It matches on the lower word's channel and an inclusive identifier range. Result: match_sect 3, match_idx = pair number.
- R6: cfg_sel values 0..3 write the start byte address of sections 0..3, and value 4 writes the end of section 3. Values 5..7 are ignored. A byte address is rounded up to a whole word. Standard frames search only sections 0 and 1, using req_id bits 10:0 alone. Extended frames search only sections 2 and 3.
- R7: A section whose start is not below its end is empty. It is skipped in one cycle with no RAM read.
- R8: Within a format, the single-identifier section is searched before the range section, and lower addresses come first. The first match wins.
- R9: Each word examined costs two cycles, and each section exit costs one. A match in word k of the first section gives done 2k+2 cycles after the request edge. done lasts one cycle. accept, match_sect and match_idx hold until the next done.
- R10: A req_valid, table write or boundary write that arrives while busy is high has no effect.
- R11: After reset, busy, done, accept, match_sect and match_idx are zero and all boundaries are zero, so every lookup is rejected. A reject reports match_sect 0 and match_idx 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Boundary register write strobe |
| cfg_sel | input | 3 | Boundary register select (0..4) |
| cfg_addr | input | AW+3 | Boundary byte address |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | AW | Table word address |
| tbl_data | input | 32 | Table word data |
| req_valid | input | 1 | Start a lookup |
| req_ext | input | 1 | Frame format: 1 extended, 0 standard |
| req_chan | input | 3 | Source channel of the frame |
| req_id | input | 29 | Received identifier |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| accept | output | 1 | Last lookup matched |
| match_sect | output | 2 | Section of the match |
| match_idx | output | AW+3 | Entry index within the section |

## Verification
A wrong scan pointer, phase or pair flag inside the block shows at the very next done pulse. It appears as a wrong verdict, a wrong section or index, or a done that comes earlier or later than 2 cycles per word plus 1 per section exit. Because each result is final within one lookup, any fault appears within a few tens of cycles of the request that meets it. Boundary or table corruption during a busy period shows up in the lookup that follows.

// File: rtl/can_af_pkg.sv
package can_af_pkg;
  localparam int CH_W  = 3;
  localparam int XID_W = 29;

  typedef enum logic [1:0] {
    SEC_EXP_STD = 2'd0,
    SEC_GRP_STD = 2'd1,
    SEC_EXP_EXT = 2'd2,
    SEC_GRP_EXT = 2'd3
  } sect_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_EVAL  = 2'd2
  } state_e;

  // 16-bit standard entry; id12 keeps the reserved bit on top of the id
  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic            dis;
    logic [11:0]     id12;
  } std_ent_t;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic [XID_W-1:0] id;
  } ext_ent_t;
endpackage

// File: rtl/can_af_bounds.sv
module can_af_bounds #(
  parameter int AW = 6,
  localparam int BW = AW + 3,
  localparam int WW = AW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [BW-1:0] wr_addr,
  input  logic          busy,
  input  logic          fmt,
  output logic [WW-1:0] start_w,
  output logic [WW-1:0] mid_w,
  output logic [WW-1:0] end_w
);
  localparam int NB = 5;

  logic [WW-1:0] bnd [NB];

  // byte address rounded up to the next whole word
  function automatic logic [WW-1:0] to_word(input logic [BW-1:0] b);
    return WW'(b[BW-1:2]) + WW'(|b[1:0]);
  endfunction

  for (genvar g = 0; g < NB; g++) begin : g_bnd
    always_ff @(posedge clk) begin
      if (rst) begin
        bnd[g] <= '0;
      end else if (wr_en && !busy && wr_sel == 3'(g)) begin
        bnd[g] <= to_word(wr_addr);
      end
    end

    // R10: boundaries frozen during a lookup
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
      (busy && wr_en) |=> $stable(bnd[g]));
  end

  assign start_w = fmt ? bnd[2] : bnd[0];
  assign mid_w   = fmt ? bnd[3] : bnd[1];
  assign end_w   = fmt ? bnd[4] : bnd[2];
endmodule

// File: rtl/can_af_table.sv
module can_af_table #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R10: no table write can land while a lookup reads the RAM
  p_rw_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(we && re));
endmodule

// File: rtl/can_af_cmp.sv
module can_af_cmp
  import can_af_pkg::*;
(
  input  sect_e       sect,
  input  logic [31:0] rdata,
  input  logic [31:0] lo_word,
  input  logic [2:0]  key_chan,
  input  logic [28:0] key_id,
  output logic        hit,
  output logic        hit_half
);
  std_ent_t eh, el;
  ext_ent_t xw, xl;
  logic [11:0] k12;
  logic mh, ml;

  assign eh  = rdata[31:16];
  assign el  = rdata[15:0];
  assign xw  = rdata;
  assign xl  = lo_word;
  assign k12 = {1'b0, key_id[10:0]};
  assign mh  = !eh.dis && eh.chan == key_chan && eh.id12 == k12;
  assign ml  = !el.dis && el.chan == key_chan && el.id12 == k12;

  always_comb begin
    hit      = 1'b0;
    hit_half = 1'b0;
    unique case (sect)
      SEC_EXP_STD: begin
        hit      = mh || ml;
        hit_half = !mh;
      end
      SEC_GRP_STD: hit = !eh.dis && !el.dis && eh.chan == key_chan &&
                         k12 >= eh.id12 && k12 <= el.id12;
      SEC_EXP_EXT: hit = xw.chan == key_chan && xw.id == key_id;
      SEC_GRP_EXT: hit = xl.chan == key_chan && key_id >= xl.id &&
                         key_id <= xw.id;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/can_af_seq.sv
module can_af_seq
  import can_af_pkg::*;
#(
  parameter int AW = 6,
  localparam int WW = AW + 2,
  localparam int IW = AW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_ext,
  input  logic [2:0]    req_chan,
  input  logic [28:0]   req_id,
  input  logic [WW-1:0] start_w,
  input  logic [WW-1:0] mid_w,
  input  logic [WW-1:0] end_w,
  input  logic [31:0]   rdata,
  input  logic          hit,
  input  logic          hit_half,
  output logic          fmt,
  output sect_e         sect,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [2:0]    key_chan,
  output logic [28:0]   key_id,
  output logic [31:0]   lo_word,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic [1:0]    match_sect,
  output logic [IW-1:0] match_idx
);
  state_e        st;
  logic          k_ext, ph, pair;
  logic [WW-1:0] cur, lo_w, hi_w, off;
  logic          in_range;
  logic [IW-1:0] idx;

  assign lo_w     = ph ? mid_w : start_w;
  assign hi_w     = ph ? end_w : mid_w;
  assign in_range = cur < hi_w;
  assign off      = cur - lo_w;
  assign sect     = sect_e'({k_ext, ph});
  assign fmt      = (st == ST_IDLE) ? req_ext : k_ext;
  assign rd_en    = (st == ST_CHECK) && in_range;
  assign rd_addr  = cur[AW-1:0];
  assign busy     = (st != ST_IDLE);

  always_comb begin
    unique case (sect)
      SEC_EXP_STD: idx = {off, hit_half};
      SEC_GRP_EXT: idx = IW'(off >> 1);
      default:     idx = IW'(off);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      k_ext      <= 1'b0;
      key_chan   <= '0;
      key_id     <= '0;
      ph         <= 1'b0;
      pair       <= 1'b0;
      cur        <= '0;
      lo_word    <= '0;
      done       <= 1'b0;
      accept     <= 1'b0;
      match_sect <= '0;
      match_idx  <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            k_ext    <= req_ext;
            key_chan <= req_chan;
            key_id   <= req_ext ? req_id : {18'd0, req_id[10:0]};
            ph       <= 1'b0;
            pair     <= 1'b0;
            cur      <= start_w;
            st       <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (in_range) begin
            st <= ST_EVAL;
          end else if (!ph) begin
            ph   <= 1'b1;
            pair <= 1'b0;
            cur  <= mid_w;
          end else begin
            done       <= 1'b1;
            accept     <= 1'b0;
            match_sect <= '0;
            match_idx  <= '0;
            st         <= ST_IDLE;
          end
        end
        ST_EVAL: begin
          if (sect == SEC_GRP_EXT && !pair) begin
            lo_word <= rdata;
            pair    <= 1'b1;
            cur     <= cur + 1'b1;
            st      <= ST_CHECK;
          end else if (hit) begin
            done       <= 1'b1;
            accept     <= 1'b1;
            match_sect <= sect;
            match_idx  <= idx;
            st         <= ST_IDLE;
          end else begin
            cur  <= cur + 1'b1;
            pair <= 1'b0;
            st   <= ST_CHECK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: done is a single-cycle strobe
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: a match always lies in a section of the frame's own format
  p_fmt_section_r6: assert property (@(posedge clk) disable iff (rst)
    (done && accept) |-> (match_sect[1] == k_ext));

  // R10: a lookup only starts from a request
  p_start_on_req_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R10: the search key is frozen while busy
  p_key_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(key_id));

  // R11: a reject reports a zero section and index
  p_reject_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !accept) |-> (match_idx == '0 && match_sect == 2'd0));
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_af_pkg::*;
#(
  parameter int AW = 6,
  localparam int BW = AW + 3,
  localparam int WW = AW + 2,
  localparam int IW = AW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [BW-1:0] cfg_addr,
  input  logic          tbl_we,
  input  logic [AW-1:0] tbl_addr,
  input  logic [31:0]   tbl_data,
  input  logic          req_valid,
  input  logic          req_ext,
  input  logic [2:0]    req_chan,
  input  logic [28:0]   req_id,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic [1:0]    match_sect,
  output logic [IW-1:0] match_idx
);
  logic          fmt, rd_en, hit, hit_half;
  logic [WW-1:0] start_w, mid_w, end_w;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rdata, lo_word;
  logic [2:0]    key_chan;
  logic [28:0]   key_id;
  sect_e         sect;

  can_af_bounds #(.AW(AW)) bounds_i (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_addr(cfg_addr), .busy(busy), .fmt(fmt),
    .start_w(start_w), .mid_w(mid_w), .end_w(end_w)
  );

  can_af_table #(.AW(AW), .DW(32)) table_i (
    .clk(clk), .rst(rst), .we(tbl_we && !busy), .waddr(tbl_addr),
    .wdata(tbl_data), .re(rd_en), .raddr(rd_addr), .rdata(rdata)
  );

  can_af_cmp cmp_i (
    .sect(sect), .rdata(rdata), .lo_word(lo_word), .key_chan(key_chan),
    .key_id(key_id), .hit(hit), .hit_half(hit_half)
  );

  can_af_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ext(req_ext),
    .req_chan(req_chan), .req_id(req_id), .start_w(start_w),
    .mid_w(mid_w), .end_w(end_w), .rdata(rdata), .hit(hit),
    .hit_half(hit_half), .fmt(fmt), .sect(sect), .rd_en(rd_en),
    .rd_addr(rd_addr), .key_chan(key_chan), .key_id(key_id),
    .lo_word(lo_word), .busy(busy), .done(done), .accept(accept),
    .match_sect(match_sect), .match_idx(match_idx)
  );
endmodule

// File: tb/can_id_filter_tb_top.sv
module can_id_filter_tb_top;
  localparam int AW = 6;
  localparam int BW = AW + 3;
  localparam int IW = AW + 3;
  localparam int NV = 23;
  localparam int TMO = 300;

  // {ext, chan, id, accept, sect, idx}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 3'd1, 29'h100,       1'b1, 2'd0, 9'd0},  // R1 upper half
    {1'b0, 3'd2, 29'h100,       1'b1, 2'd0, 9'd1},  // R1 lower, R8 over range
    {1'b0, 3'd1, 29'h200,       1'b1, 2'd0, 9'd2},  // R1
    {1'b0, 3'd1, 29'h201,       1'b0, 2'd0, 9'd0},  // R2 disabled
    {1'b0, 3'd3, 29'h7FF,       1'b1, 2'd0, 9'd4},  // R1
    {1'b0, 3'd0, 29'h000,       1'b1, 2'd0, 9'd5},  // R1
    {1'b0, 3'd1, 29'h555,       1'b0, 2'd0, 9'd0},  // R2 last entry disabled
    {1'b0, 3'd1, 29'h400,       1'b1, 2'd1, 9'd0},  // R3 low bound
    {1'b0, 3'd1, 29'h4FF,       1'b1, 2'd1, 9'd0},  // R3 high bound
    {1'b0, 3'd1, 29'h500,       1'b0, 2'd0, 9'd0},  // R3 above range
    {1'b0, 3'd2, 29'h180,       1'b1, 2'd1, 9'd1},  // R3
    {1'b0, 3'd3, 29'h180,       1'b0, 2'd0, 9'd0},  // R3 channel
    {1'b0, 3'd0, 29'h123,       1'b0, 2'd0, 9'd0},  // R2 disabled range
    {1'b1, 3'd1, 29'h1234567,   1'b1, 2'd2, 9'd0},  // R4
    {1'b1, 3'd2, 29'h1FFFFFFF,  1'b1, 2'd2, 9'd1},  // R4
    {1'b1, 3'd1, 29'h100,       1'b1, 2'd2, 9'd2},  // R4, R6
    {1'b1, 3'd4, 29'h100000,    1'b1, 2'd3, 9'd0},  // R5 low bound
    {1'b1, 3'd4, 29'h1FFFFF,    1'b1, 2'd3, 9'd0},  // R5 high bound
    {1'b1, 3'd4, 29'h200000,    1'b0, 2'd0, 9'd0},  // R5 above range
    {1'b1, 3'd1, 29'h80,        1'b1, 2'd3, 9'd1},  // R5 second pair
    {1'b0, 3'd1, 29'h300,       1'b1, 2'd0, 9'd6},  // R1
    {1'b1, 3'd1, 29'h200,       1'b0, 2'd0, 9'd0},  // R6 std-only id
    {1'b0, 3'd1, 29'h1FFFF100,  1'b1, 2'd0, 9'd0}   // R6 upper bits ignored
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we, tbl_we, req_valid, req_ext;
  logic [2:0]    cfg_sel, req_chan;
  logic [BW-1:0] cfg_addr;
  logic [AW-1:0] tbl_addr;
  logic [31:0]   tbl_data;
  logic [28:0]   req_id;
  logic          busy, done, accept;
  logic [1:0]    match_sect;
  logic [IW-1:0] match_idx;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  can_id_filter #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .req_valid(req_valid), .req_ext(req_ext),
    .req_chan(req_chan), .req_id(req_id), .busy(busy), .done(done),
    .accept(accept), .match_sect(match_sect), .match_idx(match_idx)
  );

  function automatic logic [15:0] se(input logic [2:0] ch, input logic dis,
                                     input logic [10:0] id);
    return {ch, dis, 1'b0, id};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = AW'(a); tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wr_cfg(input int s, input int b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_addr = BW'(b);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic ext, input logic [2:0] ch,
                       input logic [28:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_ext = ext; req_chan = ch; req_id = id;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // lat = clock edges after the request edge until done is seen
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < TMO) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic lookup(input logic ext, input logic [2:0] ch,
                        input logic [28:0] id, output int lat);
    issue(ext, ch, id);
    wait_done(lat);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int lat;
    rst = 1'b1; cfg_we = 1'b0; tbl_we = 1'b0; req_valid = 1'b0;
    req_ext = 1'b0; cfg_sel = '0; cfg_addr = '0; tbl_addr = '0;
    tbl_data = '0; req_chan = '0; req_id = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 busy after reset", 32'(busy), 0);
    chk("R11 done after reset", 32'(done), 0);
    chk("R11 accept after reset", 32'(accept), 0);
    chk("R11 sect after reset", 32'(match_sect), 0);
    chk("R11 idx after reset", 32'(match_idx), 0);

    // empty table after reset: reject in two cycles
    lookup(1'b0, 3'd1, 29'h100, lat);
    chk("R11 reset reject accept", 32'(accept), 0);
    chk("R7 empty sections latency", 32'(lat), 2);

    // table contents
    wr_tbl(0,  {se(3'd1, 1'b0, 11'h100), se(3'd2, 1'b0, 11'h100)});
    wr_tbl(1,  {se(3'd1, 1'b0, 11'h200), se(3'd1, 1'b1, 11'h201)});
    wr_tbl(2,  {se(3'd3, 1'b0, 11'h7FF), se(3'd0, 1'b0, 11'h000)});
    wr_tbl(3,  {se(3'd1, 1'b0, 11'h300), se(3'd1, 1'b1, 11'h555)});
    wr_tbl(4,  {se(3'd1, 1'b0, 11'h400), se(3'd1, 1'b0, 11'h4FF)});
    wr_tbl(5,  {se(3'd2, 1'b0, 11'h100), se(3'd2, 1'b0, 11'h1FF)});
    wr_tbl(6,  {se(3'd0, 1'b1, 11'h000), se(3'd0, 1'b0, 11'h7FF)});
    wr_tbl(7,  {3'd1, 29'h1234567});
    wr_tbl(8,  {3'd2, 29'h1FFFFFFF});
    wr_tbl(9,  {3'd1, 29'h100});
    wr_tbl(10, {3'd4, 29'h100000});
    wr_tbl(11, {3'd4, 29'h1FFFFF});
    wr_tbl(12, {3'd1, 29'h0});
    wr_tbl(13, {3'd1, 29'hFF});
    wr_cfg(0, 'h00);
    wr_cfg(1, 'h10);
    wr_cfg(2, 'h1C);
    wr_cfg(3, 'h28);
    wr_cfg(4, 'h38);
    wr_cfg(5, 'h00);  // R6: unused select, no effect

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      lookup(v[44], v[43:41], v[40:12], lat);
      chk($sformatf("R9 vec%0d done seen", i), 32'(lat < TMO), 1);
      chk($sformatf("R1-5 vec%0d accept", i), 32'(accept), 32'(v[11]));
      chk($sformatf("R6 vec%0d sect", i), 32'(match_sect), 32'(v[10:9]));
      chk($sformatf("R8 vec%0d idx", i), 32'(match_idx), 32'(v[8:0]));
    end

    // R9 latencies and holding
    lookup(1'b0, 3'd1, 29'h100, lat);
    chk("R9 latency word0", 32'(lat), 2);
    lookup(1'b0, 3'd3, 29'h7FF, lat);
    chk("R9 latency word2", 32'(lat), 6);
    lookup(1'b0, 3'd1, 29'h400, lat);
    chk("R9 latency range after four words", 32'(lat), 11);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
    repeat (3) @(negedge clk);
    chk("R9 accept held", 32'(accept), 1);
    chk("R9 sect held", 32'(match_sect), 1);
    chk("R9 idx held", 32'(match_idx), 0);

    // R7: empty single-standard section skipped in one cycle
    wr_cfg(0, 'h10);
    lookup(1'b0, 3'd1, 29'h400, lat);
    chk("R7 skip latency", 32'(lat), 3);
    chk("R7 range hit accept", 32'(accept), 1);
    lookup(1'b0, 3'd1, 29'h100, lat);
    chk("R7 emptied section reject", 32'(accept), 0);
    // R6: unaligned byte address rounds up to word 1
    wr_cfg(0, 'h01);
    lookup(1'b0, 3'd1, 29'h200, lat);
    chk("R6 rounded start idx", 32'(match_idx), 0);
    chk("R6 rounded start accept", 32'(accept), 1);
    lookup(1'b0, 3'd1, 29'h100, lat);
    chk("R6 rounded start skips word0", 32'(accept), 0);
    wr_cfg(0, 'h00);

    // R10: request, table and boundary writes while busy are ignored
    issue(1'b0, 3'd1, 29'h555);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'd1; req_id = 29'h100; req_ext = 1'b0;
    tbl_we = 1'b1; tbl_addr = '0; tbl_data = '0;
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_addr = BW'('h10);
    @(negedge clk);
    req_valid = 1'b0; tbl_we = 1'b0; cfg_we = 1'b0;
    wait_done(lat);
    chk("R10 first lookup result kept", 32'(accept), 0);
    repeat (2) @(negedge clk);
    chk("R10 no second lookup started", 32'(busy), 0);
    lookup(1'b0, 3'd1, 29'h100, lat);
    chk("R10 table and bounds unchanged accept", 32'(accept), 1);
    chk("R10 table and bounds unchanged idx", 32'(match_idx), 0);
    chk("R10 table and bounds unchanged lat", 32'(lat), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule